// File: doc/BRIEF.md
# Parallel Grid Integer Matrix Multiplier

This block forms the product C = A x B of two square signed integer matrices whose order n can be anything from 1 up to the edge length of a fixed grid of multiply-accumulate cells. The default grid is 12 by 12. A run has four phases that always come in the same order. First the A operand arrives over a valid/ready input stream and is held in a register array. The B operand then arrives over the same stream into a second register array. Next comes a compute phase of n cycles. Last, the n*n results go out over a valid/ready output stream.

Both operand arrays are fully partitioned, so every cell reads its own A row element and B column element straight from them in the same cycle. Cells do not pass data to their neighbours. Because the arithmetic is integer, each cell adds one product to its 32-bit wrapping accumulator per cycle. In compute cycle k, cell (i,j) adds A[i][k]*B[k][j].

A controller sequences the phases and sends a small set of strobes to the datapath, which holds the arrays and the cells. The user drives the order on `size`, pulses `start`, streams both operands, drains the result, and waits for `done`.

Top module: `mat_grid_mul`

## Requirements
- R1: After reset, inReady, outValid and done are all low.
- R2: A start seen while the block is idle latches the order n from size and raises inReady in the next cycle. A size of 0, or any value above the grid edge (12), is treated as 12. inReady rises only after such a start.
- R3: The block accepts exactly n*n words of A and then n*n words of B, both row-major (column index fastest), each word taken on a cycle with inValid and inReady both high. Gaps in inValid do not disturb loading.
- R4: Each output word C[i][j] is the sum over k of A[i][k]*B[k][j], with the 32-bit signed operands multiplied and accumulated modulo 2^32.
- R5: C leaves as n*n words in row-major order. While outValid is high and outReady is low, outValid stays high and outData does not change.
- R6: outValid first rises n+1 falling clock edges after the rising edge that takes the last B word. This means the compute phase lasts exactly n cycles.
- R7: done is high for exactly one cycle: the cycle right after the last C word is accepted. After that the block is idle and neither inReady nor outValid is high.
- R8: A start raised while a run is in progress, including in the cycle its last C word is accepted, is ignored. The run's results are unchanged and no new load begins.
- R9: Every run clears all accumulators. A run of smaller order that follows a larger one gives results free of stale data.
- R10: inReady and outValid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| size | input | 4 | Matrix order n, latched at start |
| inValid | input | 1 | Operand word present on inData |
| inReady | output | 1 | Block accepts an operand word |
| inData | input | 32 | Signed operand word, A then B, row-major |
| outValid | output | 1 | Result word present on outData |
| outReady | input | 1 | Consumer takes the result word |
| outData | output | 32 | Signed result word, row-major |
| done | output | 1 | One-cycle pulse after the last result word |

## Verification
The last accepted result word and a fresh start request can land in the same cycle. The controller must then finish the run and ignore the request rather than reopen loading. The bench provokes this by raising start together with the final C beat of a run. It then requires a single done pulse on the next cycle, followed by an idle block with inReady low. A start inside the A load is also injected, and the results of that run must still match the product the bench computes. A full sweep of every order from 1 to 12 covers the other paths, with stalls on both streams and full-range operands that force wraparound.

// File: rtl/mat_grid_pkg.sv
package mat_grid_pkg;

  // Per-cycle commands from the phase sequencer to the datapath.
  typedef struct packed {
    logic clrAcc;  // zero every accumulator
    logic wrA;     // store inData into the A array
    logic wrB;     // store inData into the B array
    logic accum;   // one multiply-accumulate step on all cells
  } strobe_t;

endpackage

// File: rtl/mat_grid_cell.sv
module mat_grid_cell #(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [DW-1:0] acc
);

  // Integer accumulate finishes in a single cycle; result wraps modulo 2^DW.
  always_ff @(posedge clk) begin
    if (clr) begin
      acc <= '0;
    end else if (en) begin
      acc <= acc + a * b;
    end
  end

endmodule

// File: rtl/mat_grid_ctrl.sv
module mat_grid_ctrl
  import mat_grid_pkg::*;
#(
  parameter int DIM = 12,
  parameter int IW  = 4,
  parameter int SW  = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [SW-1:0] size,
  input  logic          inValid,
  input  logic          outReady,
  output logic          inReady,
  output logic          outValid,
  output logic          done,
  output strobe_t       stb,
  output logic [IW-1:0] rowIdx,
  output logic [IW-1:0] colIdx,
  output logic [IW-1:0] kIdx
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOADA,
    S_LOADB,
    S_COMP,
    S_WRITE
  } phase_e;

  phase_e        state;
  logic [SW-1:0] nReg;
  logic [SW-1:0] sizeEff;
  logic [IW-1:0] row;
  logic [IW-1:0] col;
  logic [IW-1:0] k;
  logic [IW-1:0] lastIdx;
  logic          doneReg;
  logic          inFire;
  logic          outFire;

  assign sizeEff = (size == '0 || size > SW'(DIM)) ? SW'(DIM) : size;
  assign lastIdx = IW'(nReg - SW'(1));

  assign inReady  = (state == S_LOADA) || (state == S_LOADB);
  assign outValid = (state == S_WRITE);
  assign inFire   = inValid && inReady;
  assign outFire  = outValid && outReady;
  assign done     = doneReg;

  assign stb.clrAcc = (state == S_IDLE) && start;
  assign stb.wrA    = (state == S_LOADA) && inFire;
  assign stb.wrB    = (state == S_LOADB) && inFire;
  assign stb.accum  = (state == S_COMP);

  assign rowIdx = row;
  assign colIdx = col;
  assign kIdx   = k;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      nReg    <= SW'(DIM);
      row     <= '0;
      col     <= '0;
      k       <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            nReg  <= sizeEff;
            row   <= '0;
            col   <= '0;
            k     <= '0;
            state <= S_LOADA;
          end
        end
        S_LOADA, S_LOADB: begin
          if (inFire) begin
            if (col == lastIdx) begin
              col <= '0;
              if (row == lastIdx) begin
                row   <= '0;
                state <= (state == S_LOADA) ? S_LOADB : S_COMP;
              end else begin
                row <= row + 1'b1;
              end
            end else begin
              col <= col + 1'b1;
            end
          end
        end
        S_COMP: begin
          if (k == lastIdx) begin
            k     <= '0;
            state <= S_WRITE;
          end else begin
            k <= k + 1'b1;
          end
        end
        S_WRITE: begin
          if (outFire) begin
            if (col == lastIdx) begin
              col <= '0;
              if (row == lastIdx) begin
                row     <= '0;
                state   <= S_IDLE;
                doneReg <= 1'b1;
              end else begin
                row <= row + 1'b1;
              end
            end else begin
              col <= col + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mat_grid_dp.sv
module mat_grid_dp
  import mat_grid_pkg::*;
#(
  parameter int DIM = 12,
  parameter int DW  = 32,
  parameter int IW  = 4
) (
  input  logic                 clk,
  input  strobe_t              stb,
  input  logic [IW-1:0]        rowIdx,
  input  logic [IW-1:0]        colIdx,
  input  logic [IW-1:0]        kIdx,
  input  logic signed [DW-1:0] inData,
  output logic signed [DW-1:0] outData
);

  // Fully partitioned operand storage: every element is its own register.
  logic signed [DW-1:0] aMem   [DIM][DIM];
  logic signed [DW-1:0] bMem   [DIM][DIM];
  logic signed [DW-1:0] accArr [DIM][DIM];

  always_ff @(posedge clk) begin
    if (stb.wrA) begin
      aMem[rowIdx][colIdx] <= inData;
    end
    if (stb.wrB) begin
      bMem[rowIdx][colIdx] <= inData;
    end
  end

  // Every cell takes its operands directly from the arrays, not from a neighbour.
  for (genvar gi = 0; gi < DIM; gi++) begin : g_row
    for (genvar gj = 0; gj < DIM; gj++) begin : g_col
      mat_grid_cell #(.DW(DW)) u_cell (
        .clk (clk),
        .clr (stb.clrAcc),
        .en  (stb.accum),
        .a   (aMem[gi][kIdx]),
        .b   (bMem[kIdx][gj]),
        .acc (accArr[gi][gj])
      );
    end
  end

  assign outData = accArr[rowIdx][colIdx];

endmodule

// File: rtl/mat_grid_mul.sv
module mat_grid_mul
  import mat_grid_pkg::*;
#(
  parameter  int DIM = 12,
  parameter  int DW  = 32,
  localparam int SW  = $clog2(DIM + 1),
  localparam int IW  = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [SW-1:0] size,
  input  logic          inValid,
  output logic          inReady,
  input  logic [DW-1:0] inData,
  output logic          outValid,
  input  logic          outReady,
  output logic [DW-1:0] outData,
  output logic          done
);

  strobe_t       stb;
  logic [IW-1:0] rowIdx;
  logic [IW-1:0] colIdx;
  logic [IW-1:0] kIdx;

  mat_grid_ctrl #(.DIM(DIM), .IW(IW), .SW(SW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .size     (size),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .done     (done),
    .stb      (stb),
    .rowIdx   (rowIdx),
    .colIdx   (colIdx),
    .kIdx     (kIdx)
  );

  mat_grid_dp #(.DIM(DIM), .DW(DW), .IW(IW)) u_dp (
    .clk     (clk),
    .stb     (stb),
    .rowIdx  (rowIdx),
    .colIdx  (colIdx),
    .kIdx    (kIdx),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/mat_grid_chk.sv
module mat_grid_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          inValid,
  input logic          inReady,
  input logic          outValid,
  input logic          outReady,
  input logic [DW-1:0] outData,
  input logic          done
);

  // R10: never loading and emitting at once
  p_phase_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  // R2: loading opens only in response to a start
  p_load_after_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> $past(start));

  // R5: a stalled result word is held
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R7: done follows an accepted result word
  p_done_after_beat_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(outValid && outReady));

  // R7: done lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: idle while done is shown
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!inReady && !outValid));

endmodule

bind mat_grid_mul mat_grid_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .done     (done)
);

// File: tb/mat_grid_mul_bench.sv
module mat_grid_mul_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIM = 12;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    size = '0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [DW-1:0] inData = '0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [DW-1:0] outData;
  logic          done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int seed = 32'h1234_5678;

  int matA [DIM][DIM];
  int matB [DIM][DIM];
  int expC [DIM][DIM];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mat_grid_mul #(.DIM(DIM), .DW(DW)) u_mat_grid_mul (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .size     (size),
    .inValid  (inValid),
    .inReady  (inReady),
    .inData   (inData),
    .outValid (outValid),
    .outReady (outReady),
    .outData  (outData),
    .done     (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return seed;
  endfunction

  task automatic sendWord(input int d);
    inValid = 1'b1;
    inData  = d;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  // pattern 0: full-range pseudo-random, 1: extreme values
  // gaps: stalls on both streams; midStart: start pulse during A load;
  // endStart: start raised with the final result beat
  task automatic doRun(input int n, input int sizeIn, input int pattern,
                       input bit gaps, input bit midStart, input bit endStart);
    int lat;
    int beat;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < n; j++) begin
        if (pattern == 0) begin
          matA[i][j] = nextRand();
          matB[i][j] = nextRand();
        end else begin
          matA[i][j] = ((i + j) % 2 == 0) ? 32'sh7fff_ffff : 32'sh8000_0000;
          matB[i][j] = ((i * j) % 3 == 0) ? -1 : 32'sh7fff_fffd;
        end
      end
    end
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < n; j++) begin
        int s = 0;
        for (int k = 0; k < n; k++) s += matA[i][k] * matB[k][j];
        expC[i][j] = s;
      end
    end

    @(negedge clk);
    check(!inReady, "R2 idle before start", int'(inReady), 0);
    start = 1'b1;
    size  = 4'(sizeIn);
    @(negedge clk);
    start = 1'b0;
    size  = 4'd1;
    check(inReady, "R2 inReady after start", int'(inReady), 1);

    beat = 0;
    for (int ph = 0; ph < 2; ph++) begin
      for (int i = 0; i < n; i++) begin
        for (int j = 0; j < n; j++) begin
          if (gaps && (beat % 3 == 2)) begin
            inValid = 1'b0;
            @(negedge clk);
          end
          if (midStart && beat == 1) start = 1'b1;
          if (midStart && beat == 2) start = 1'b0;
          sendWord(ph == 0 ? matA[i][j] : matB[i][j]);
          beat++;
        end
      end
    end
    inValid = 1'b0;
    start   = 1'b0;

    lat = 1;
    while (!outValid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(lat == n + 1, "R6 compute latency", lat, n + 1);
    check(!inReady, "R3 load closed after n*n B words", int'(inReady), 0);

    beat = 0;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < n; j++) begin
        if (gaps && (beat % 4 == 1)) begin
          logic [DW-1:0] held;
          held = outData;
          outReady = 1'b0;
          @(negedge clk);
          @(negedge clk);
          check(outValid && outData == held, "R5 held under stall",
                int'(outData), int'(held));
        end
        check(outValid, "R5 outValid for result beat", int'(outValid), 1);
        check(int'(outData) == expC[i][j], "R4 product value",
              int'(outData), expC[i][j]);
        outReady = 1'b1;
        if (endStart && i == n - 1 && j == n - 1) begin
          start = 1'b1;
          size  = 4'd3;
        end
        @(posedge clk);
        @(negedge clk);
        outReady = 1'b0;
        start    = 1'b0;
        if (!(i == n - 1 && j == n - 1)) begin
          check(!done, "R7 no done before last beat", int'(done), 0);
        end
        beat++;
      end
    end
    check(done, "R7 done after last beat", int'(done), 1);
    check(!outValid, "R5 exactly n*n beats", int'(outValid), 0);
    @(negedge clk);
    check(!done, "R7 done lasts one cycle", int'(done), 0);
    check(!inReady && !outValid, "R8 idle after run, late start ignored",
          int'(inReady) + int'(outValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!inReady && !outValid && !done, "R1 reset outputs",
          int'(inReady) + int'(outValid) + int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!inReady && !outValid && !done, "R1 idle after reset release",
          int'(inReady) + int'(outValid) + int'(done), 0);

    // R3 R4 R5 R6 sweep over every order
    for (int n = 1; n <= DIM; n++) doRun(n, n, 0, (n % 2) == 1, 1'b0, 1'b0);
    // R9 small order after the full one
    doRun(2, 2, 0, 1'b0, 1'b0, 1'b0);
    // R4 wraparound with extreme operands
    doRun(3, 3, 1, 1'b1, 1'b0, 1'b0);
    doRun(DIM, DIM, 1, 1'b0, 1'b0, 1'b0);
    // R2 out-of-range sizes map to the full grid
    doRun(DIM, 0, 0, 1'b0, 1'b0, 1'b0);
    doRun(DIM, 15, 0, 1'b1, 1'b0, 1'b0);
    // R8 start during load and start with the final beat
    doRun(4, 4, 0, 1'b0, 1'b1, 1'b0);
    doRun(2, 2, 0, 1'b1, 1'b0, 1'b1);
    doRun(1, 1, 0, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule